// File: doc/BRIEF.md
# Page Access Fault Checker

This block takes one already-translated memory access together with the attribute bits gathered from every level of the page-table walk and decides whether the access must raise a page fault. It reduces the per-level present, writable, user-accessible, no-execute and reserved-bit flags to effective permissions. It then applies the privilege rules for the access kind (read, write or instruction fetch) and the current privilege level. It also applies the supervisor write-protect control.

The fault decision and a five-bit error code are combinational, so they are valid in the same cycle as the access. The faulting linear address is registered on the clock edge of any valid access that faults and holds its value until the next fault. The table walker and the translation cache sit outside this block. They present one access per cycle with `acc_valid` and read back the verdict.

Top module: `pf_access_check`

## Requirements
- R1: If the present bit is clear at any level during a valid access, `fault` is 1 and error-code bit 0 is 0; bit 3 is then 0 even if reserved bits are flagged.
- R2: A valid access at privilege 3 faults if the user-accessible bit is clear at any level. The error code then has bit 0 set.
- R3: A valid write at privilege 3 faults if the writable bit is clear at any level.
- R4: A valid write at privilege 0, 1 or 2 to a page that is read-only at any level faults only when `wp_en` is 1. Supervisor accesses never fault on the user-accessible bit.
- R5: A valid fetch (`acc_kind` 2) faults if the no-execute bit is set at any level. Reads and writes ignore no-execute.
- R6: With all levels present, any reserved-bit flag set makes a valid access fault. Error-code bits 0 and 3 are then both 1.
- R7: On a fault the error code holds the access details. Bit 1 is set for a write (`acc_kind` 1), bit 2 for privilege 3, and bit 4 for a fetch. Without a fault the code is 0.
- R8: While `acc_valid` is 0, `fault` and `fault_code` are 0 and `fault_addr` does not change.
- R9: On the clock edge of a valid faulting access, `fault_addr` takes `lin_addr`. It holds otherwise and is 0 after reset.
- R10: `acc_kind` value 3 is treated as a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 read |
| cpl | input | 2 | Current privilege level |
| wp_en | input | 1 | Supervisor write-protect enable |
| lvl_present | input | LEVELS | Present bit per level |
| lvl_writable | input | LEVELS | Writable bit per level |
| lvl_user | input | LEVELS | User-accessible bit per level |
| lvl_nx | input | LEVELS | No-execute bit per level |
| lvl_rsvd | input | LEVELS | Reserved bits set, per level |
| lin_addr | input | VA_W | Linear address of the access |
| fault | output | 1 | Access faults |
| fault_code | output | 5 | Error code |
| fault_addr | output | VA_W | Last faulting linear address |

## Verification
The bench targets the interactions between rules. A not-present level combined with reserved bits must report not-present. A design with the wrong priority would set bits 0 and 3. Supervisor writes to read-only pages are tried with write-protect both on and off; a design that ignored `wp_en` would fault or pass in both cases. A single denying level among permissive ones is tested to catch a design that uses an OR instead of an AND. Reads with no-execute set and kind 3 are checked for spurious faults. The bench also checks that the address register holds across non-faulting and idle cycles, which catches a design that captures on every access.

// File: rtl/pf_pkg.sv
// Package: shared types and error-code bit positions for the page fault checker.
// Assumes a two-bit access kind; value 3 is decoded as a read.
package pf_pkg;
    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_ALT   = 2'd3
    } acc_kind_e;

    localparam int PF_CODE_W = 5;
    localparam int PF_BIT_PROT  = 0;
    localparam int PF_BIT_WRITE = 1;
    localparam int PF_BIT_USER  = 2;
    localparam int PF_BIT_RSVD  = 3;
    localparam int PF_BIT_FETCH = 4;

    localparam logic [1:0] PF_USER_CPL = 2'd3;
endpackage

// File: rtl/pf_level_merge.sv
// Module: folds per-level attribute bits into effective flags.
// Permissions combine with AND, denials with OR, by a generate chain per level.
// Assumes LEVELS >= 1; bit i belongs to walk level i.
module pf_level_merge #(
    parameter int LEVELS = 4
) (
    input  logic [LEVELS-1:0] present_i,
    input  logic [LEVELS-1:0] writable_i,
    input  logic [LEVELS-1:0] user_i,
    input  logic [LEVELS-1:0] nx_i,
    input  logic [LEVELS-1:0] rsvd_i,
    output logic              all_present_o,
    output logic              all_writable_o,
    output logic              all_user_o,
    output logic              any_nx_o,
    output logic              any_rsvd_o
);
    logic [LEVELS:0] pres_c, wr_c, us_c, nx_c, rs_c;

    assign pres_c[0] = 1'b1;
    assign wr_c[0]   = 1'b1;
    assign us_c[0]   = 1'b1;
    assign nx_c[0]   = 1'b0;
    assign rs_c[0]   = 1'b0;

    // One link of each chain per walk level.
    for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
        assign pres_c[g+1] = pres_c[g] & present_i[g];
        assign wr_c[g+1]   = wr_c[g]   & writable_i[g];
        assign us_c[g+1]   = us_c[g]   & user_i[g];
        assign nx_c[g+1]   = nx_c[g]   | nx_i[g];
        assign rs_c[g+1]   = rs_c[g]   | rsvd_i[g];
    end

    assign all_present_o  = pres_c[LEVELS];
    assign all_writable_o = wr_c[LEVELS];
    assign all_user_o     = us_c[LEVELS];
    assign any_nx_o       = nx_c[LEVELS];
    assign any_rsvd_o     = rs_c[LEVELS];
endmodule

// File: rtl/pf_rule_eval.sv
// Module: applies privilege, write-protect and no-execute rules to merged flags.
// Outputs the three fault classes and the decoded access attributes.
// Assumes merged inputs are from pf_level_merge; kind 3 decodes as read.
module pf_rule_eval
    import pf_pkg::*;
(
    input  logic [1:0] kind_i,
    input  logic [1:0] cpl_i,
    input  logic       wp_en_i,
    input  logic       all_present_i,
    input  logic       all_writable_i,
    input  logic       all_user_i,
    input  logic       any_nx_i,
    input  logic       any_rsvd_i,
    output logic       not_present_o,
    output logic       rsvd_viol_o,
    output logic       prot_viol_o,
    output logic       is_write_o,
    output logic       is_user_o,
    output logic       is_fetch_o
);
    logic user_deny, write_deny, exec_deny;

    // Decode access kind and privilege class.
    always_comb begin
        is_write_o = (acc_kind_e'(kind_i) == ACC_WRITE);
        is_fetch_o = (acc_kind_e'(kind_i) == ACC_FETCH);
        is_user_o  = (cpl_i == PF_USER_CPL);
    end

    // Evaluate each protection rule separately.
    always_comb begin
        user_deny  = is_user_o & ~all_user_i;
        write_deny = is_write_o & ~all_writable_i & (is_user_o | wp_en_i);
        exec_deny  = is_fetch_o & any_nx_i;
    end

    // Rank classes: not-present first, then reserved, then protection.
    always_comb begin
        not_present_o = ~all_present_i;
        rsvd_viol_o   = all_present_i & any_rsvd_i;
        prot_viol_o   = all_present_i & (user_deny | write_deny | exec_deny);
    end
endmodule

// File: rtl/pf_code_gen.sv
// Module: forms the fault flag and the five-bit error code.
// Assumes fault classes arrive already ranked; the code is zero without a fault.
module pf_code_gen
    import pf_pkg::*;
(
    input  logic                 valid_i,
    input  logic                 not_present_i,
    input  logic                 rsvd_viol_i,
    input  logic                 prot_viol_i,
    input  logic                 is_write_i,
    input  logic                 is_user_i,
    input  logic                 is_fetch_i,
    output logic                 fault_o,
    output logic [PF_CODE_W-1:0] code_o
);
    // Gate the fault with the access strobe and pack the code fields.
    always_comb begin
        fault_o = valid_i & (not_present_i | rsvd_viol_i | prot_viol_i);
        code_o  = '0;
        if (fault_o) begin
            code_o[PF_BIT_PROT]  = ~not_present_i;
            code_o[PF_BIT_WRITE] = is_write_i;
            code_o[PF_BIT_USER]  = is_user_i;
            code_o[PF_BIT_RSVD]  = rsvd_viol_i;
            code_o[PF_BIT_FETCH] = is_fetch_i;
        end
    end
endmodule

// File: rtl/pf_addr_capture.sv
// Module: faulting-address register, loaded only on a faulting access.
// Assumes synchronous active-low reset; resets to zero.
module pf_addr_capture #(
    parameter int VA_W = 48
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic [VA_W-1:0] addr_i,
    output logic [VA_W-1:0] addr_o
);
    // Hold the last faulting address.
    always_ff @(posedge clk) begin
        if (!rst_n)      addr_o <= '0;
        else if (load_i) addr_o <= addr_i;
    end

    assert_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (addr_o == $past(addr_i)));
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(addr_o));
endmodule

// File: rtl/pf_access_check.sv
// Module: top of the page access fault checker.
// Merges per-level attributes, applies the access rules, emits fault and
// error code combinationally and captures the faulting address.
// Assumes one access per cycle, qualified by acc_valid.
module pf_access_check
    import pf_pkg::*;
#(
    parameter int LEVELS = 4,
    parameter int VA_W   = 48
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 acc_valid,
    input  logic [1:0]           acc_kind,
    input  logic [1:0]           cpl,
    input  logic                 wp_en,
    input  logic [LEVELS-1:0]    lvl_present,
    input  logic [LEVELS-1:0]    lvl_writable,
    input  logic [LEVELS-1:0]    lvl_user,
    input  logic [LEVELS-1:0]    lvl_nx,
    input  logic [LEVELS-1:0]    lvl_rsvd,
    input  logic [VA_W-1:0]      lin_addr,
    output logic                 fault,
    output logic [PF_CODE_W-1:0] fault_code,
    output logic [VA_W-1:0]      fault_addr
);
    logic all_present, all_writable, all_user, any_nx, any_rsvd;
    logic not_present, rsvd_viol, prot_viol;
    logic is_write, is_user, is_fetch;

    pf_level_merge #(.LEVELS(LEVELS)) u_merge (
        .present_i      (lvl_present),
        .writable_i     (lvl_writable),
        .user_i         (lvl_user),
        .nx_i           (lvl_nx),
        .rsvd_i         (lvl_rsvd),
        .all_present_o  (all_present),
        .all_writable_o (all_writable),
        .all_user_o     (all_user),
        .any_nx_o       (any_nx),
        .any_rsvd_o     (any_rsvd)
    );

    pf_rule_eval u_rules (
        .kind_i         (acc_kind),
        .cpl_i          (cpl),
        .wp_en_i        (wp_en),
        .all_present_i  (all_present),
        .all_writable_i (all_writable),
        .all_user_i     (all_user),
        .any_nx_i       (any_nx),
        .any_rsvd_i     (any_rsvd),
        .not_present_o  (not_present),
        .rsvd_viol_o    (rsvd_viol),
        .prot_viol_o    (prot_viol),
        .is_write_o     (is_write),
        .is_user_o      (is_user),
        .is_fetch_o     (is_fetch)
    );

    pf_code_gen u_code (
        .valid_i       (acc_valid),
        .not_present_i (not_present),
        .rsvd_viol_i   (rsvd_viol),
        .prot_viol_i   (prot_viol),
        .is_write_i    (is_write),
        .is_user_i     (is_user),
        .is_fetch_i    (is_fetch),
        .fault_o       (fault),
        .code_o        (fault_code)
    );

    pf_addr_capture #(.VA_W(VA_W)) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (fault),
        .addr_i (lin_addr),
        .addr_o (fault_addr)
    );

    assert_notpresent_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !(&lvl_present)) |-> (fault && !fault_code[PF_BIT_PROT] && !fault_code[PF_BIT_RSVD]));
    assert_rsvd_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && (&lvl_present) && (|lvl_rsvd)) |-> (fault && fault_code[PF_BIT_RSVD] && fault_code[PF_BIT_PROT]));
    assert_nx_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && (&lvl_present) && acc_kind == 2'd2 && (|lvl_nx)) |-> (fault && fault_code[PF_BIT_FETCH]));
    assert_code_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !fault |-> (fault_code == '0));
    assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> $stable(fault_addr));
endmodule

// File: tb/sim_pf_access_check.sv
`timescale 1ns/1ps
module sim_pf_access_check;
    localparam int LV = 4;
    localparam int AW = 48;
    localparam int NV = 15;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          acc_valid = 1'b0;
    logic [1:0]    acc_kind = '0;
    logic [1:0]    cpl = '0;
    logic          wp_en = 1'b0;
    logic [LV-1:0] lvl_present = '1, lvl_writable = '1, lvl_user = '1, lvl_nx = '0, lvl_rsvd = '0;
    logic [AW-1:0] lin_addr = '0;
    logic          fault;
    logic [4:0]    fault_code;
    logic [AW-1:0] fault_addr;

    int checks = 0;
    int errors = 0;
    logic [AW-1:0] exp_addr = '0;

    always #2.5 clk = ~clk;

    pf_access_check #(.LEVELS(LV), .VA_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_kind(acc_kind),
        .cpl(cpl), .wp_en(wp_en), .lvl_present(lvl_present), .lvl_writable(lvl_writable),
        .lvl_user(lvl_user), .lvl_nx(lvl_nx), .lvl_rsvd(lvl_rsvd), .lin_addr(lin_addr),
        .fault(fault), .fault_code(fault_code), .fault_addr(fault_addr));

    // kind, cpl, wp, present, writable, user, nx, rsvd, exp fault, exp code
    localparam logic [30:0] VEC [NV] = '{
        {2'd0, 2'd0, 1'b0, 4'hF, 4'hF, 4'hF, 4'h0, 4'h0, 1'b0, 5'b00000}, // R7 clean read
        {2'd0, 2'd3, 1'b0, 4'hB, 4'hF, 4'hF, 4'h0, 4'h0, 1'b1, 5'b00100}, // R1
        {2'd1, 2'd0, 1'b0, 4'hE, 4'hF, 4'hF, 4'h0, 4'h0, 1'b1, 5'b00010}, // R1
        {2'd0, 2'd3, 1'b0, 4'hF, 4'hF, 4'hD, 4'h0, 4'h0, 1'b1, 5'b00101}, // R2
        {2'd0, 2'd0, 1'b0, 4'hF, 4'hF, 4'h0, 4'h0, 4'h0, 1'b0, 5'b00000}, // R4
        {2'd1, 2'd3, 1'b0, 4'hF, 4'h7, 4'hF, 4'h0, 4'h0, 1'b1, 5'b00111}, // R3
        {2'd0, 2'd3, 1'b0, 4'hF, 4'h0, 4'hF, 4'h0, 4'h0, 1'b0, 5'b00000}, // R3
        {2'd1, 2'd1, 1'b0, 4'hF, 4'hB, 4'hF, 4'h0, 4'h0, 1'b0, 5'b00000}, // R4
        {2'd1, 2'd2, 1'b1, 4'hF, 4'hB, 4'hF, 4'h0, 4'h0, 1'b1, 5'b00011}, // R4
        {2'd2, 2'd0, 1'b0, 4'hF, 4'hF, 4'hF, 4'h2, 4'h0, 1'b1, 5'b10001}, // R5
        {2'd0, 2'd3, 1'b0, 4'hF, 4'hF, 4'hF, 4'hF, 4'h0, 1'b0, 5'b00000}, // R5
        {2'd2, 2'd3, 1'b0, 4'hF, 4'hF, 4'hF, 4'h0, 4'h4, 1'b1, 5'b11101}, // R6
        {2'd1, 2'd0, 1'b0, 4'h7, 4'hF, 4'hF, 4'h0, 4'h8, 1'b1, 5'b00010}, // R1
        {2'd3, 2'd3, 1'b0, 4'hF, 4'h0, 4'hF, 4'hF, 4'h0, 1'b0, 5'b00000}, // R10
        {2'd1, 2'd3, 1'b1, 4'hF, 4'hF, 4'hF, 4'h0, 4'h0, 1'b0, 5'b00000}  // R7
    };

    function automatic string vtag(input int i);
        case (i)
            1, 2, 12: vtag = "R1";
            3:        vtag = "R2";
            5, 6:     vtag = "R3";
            4, 7, 8:  vtag = "R4";
            9, 10:    vtag = "R5";
            11:       vtag = "R6";
            13:       vtag = "R10";
            default:  vtag = "R7";
        endcase
    endfunction

    task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R9 reset addr", fault_addr, '0);
        chk("R8 reset fault", {47'd0, fault}, '0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            acc_valid = 1'b1;
            {acc_kind, cpl, wp_en, lvl_present, lvl_writable, lvl_user, lvl_nx, lvl_rsvd} = VEC[i][30:6];
            lin_addr = 48'h7f00_0000_1000 + AW'(i) * 48'h0000_0001_1234;
            #1;
            chk({vtag(i), " fault"}, {47'd0, fault}, {47'd0, VEC[i][5]});
            chk({vtag(i), " code"}, {43'd0, fault_code}, {43'd0, VEC[i][4:0]});
            if (VEC[i][5]) exp_addr = lin_addr;
            @(posedge clk);
            #1;
            chk("R9 fault_addr", fault_addr, exp_addr);
        end

        // R8: idle cycle with faulting attributes has no effect
        @(negedge clk);
        acc_valid = 1'b0;
        lvl_present = 4'h0;
        lin_addr = 48'h1234_5678_9abc;
        #1;
        chk("R8 idle fault", {47'd0, fault}, '0);
        chk("R8 idle code", {43'd0, fault_code}, '0);
        @(posedge clk);
        #1;
        chk("R8 idle addr", fault_addr, exp_addr);

        // R9: a new fault replaces the address, then reset clears it
        @(negedge clk);
        acc_valid = 1'b1;
        lin_addr = 48'h0000_dead_b000;
        @(posedge clk);
        #1;
        chk("R9 recapture", fault_addr, 48'h0000_dead_b000);
        @(negedge clk);
        rst_n = 1'b0;
        acc_valid = 1'b0;
        @(posedge clk);
        #1;
        chk("R9 reset clears", fault_addr, '0);
        rst_n = 1'b1;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule